// File: doc/BRIEF.md
# Receive Sample Format Packer

This block sits at the end of a receive datapath and turns a stream of complex samples (16-bit signed I and Q) into 16-bit output words for a host link. A single 32-bit format word, loaded through a write strobe, chooses how the samples are cut down. It sets an arithmetic right shift, the width kept after the shift, and whether the Q part is sent at all. Narrow 8-bit samples go two to a word, so the link carries half as many words.

Two sample streams enter the block: one comes from the decimating filter and the other bypasses it. Each has its own valid strobe. One bit of the format word picks the stream to use. The filter itself is not part of this block. Only two format combinations are honoured: full 16-bit samples with no shift, and 8-bit samples with an 8-bit shift. Any other setting falls back to full 16-bit samples with no shift, and the Q-delivery bit is still obeyed.

Top module: `rx_fmt_packer`

## Requirements
- R1: After reset, out_valid is 0, out_data is 0 and the format word is all zeros: filtered stream, I only, 16-bit samples.
- R2: Format fields: shift amount in bits 3:0, sample width in bits 8:4, Q-delivery in bit 9, stream select in bit 10, bits 31:11 reserved. The 8-bit mode is used only when width is 8, shift is 8 and bits 31:11 are zero. Every other value gives 16-bit samples with zero shift.
- R3: With bit 10 set, samples are taken from raw_valid/raw_i/raw_q and the filtered inputs have no effect. With bit 10 clear, it is the other way round.
- R4: In 16-bit mode with Q delivery, a sample accepted at clock edge k puts out the I word in the cycle after edge k. It then puts out the Q word in the cycle after edge k+1.
- R5: In 16-bit mode without Q delivery, each accepted sample gives exactly one word, equal to I, in the cycle after the edge that accepted it.
- R6: In 8-bit mode with Q delivery, each accepted sample gives one word in the next cycle. Bits 7:0 hold the low byte of I shifted right arithmetically by 8, and bits 15:8 hold the same for Q.
- R7: In 8-bit mode without Q delivery, two accepted samples make one word. The first sample's byte goes in bits 7:0 and the second's in bits 15:8. The word appears in the cycle after the second sample, and no word appears after the first.
- R8: A sample that arrives in the cycle a pending Q word is being sent is discarded and produces no output.
- R9: A format write takes effect for samples after its edge. A sample in the same cycle as the write is handled under the old format. The write discards any byte held for pairing, including one stored in that same cycle.
- R10: out_data is zero in every cycle where out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_we | input | 1 | Format word write strobe |
| fmt_wdata | input | 32 | Format word |
| filt_valid | input | 1 | Filtered sample strobe |
| filt_i | input | 16 | Filtered sample, I part |
| filt_q | input | 16 | Filtered sample, Q part |
| raw_valid | input | 1 | Unfiltered sample strobe |
| raw_i | input | 16 | Unfiltered sample, I part |
| raw_q | input | 16 | Unfiltered sample, Q part |
| out_valid | output | 1 | Output word strobe |
| out_data | output | 16 | Output word |

## Verification
Two kinds of collision are driven on purpose. In the first, a new sample arrives in the same cycle that the Q word of the previous sample goes out; the reference model expects the Q word and no trace of the new sample. In the second, a format write meets a sample in one cycle, both when a pair is half filled and when the sample would start a new pair; the model applies the old format to that sample and then drops the held byte. The bench compares the outputs with the model on every clock, so a word that is lost, duplicated or late shows up in the exact cycle where it goes wrong.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  localparam int CFG_W      = 32;
  localparam int SHIFT_LSB  = 0;
  localparam int SHIFT_W    = 4;
  localparam int WIDTH_LSB  = 4;
  localparam int WIDTH_W    = 5;
  localparam int WANTQ_BIT  = 9;
  localparam int RAWSEL_BIT = 10;
  localparam int RSVD_LSB   = 11;

  typedef struct packed {
    logic               narrow;
    logic               want_q;
    logic               use_raw;
    logic [SHIFT_W-1:0] shift;
  } fmt_mode_t;

  // Only the exact narrow combination is honoured; all else is full width, no shift.
  function automatic fmt_mode_t decode_fmt(input logic [CFG_W-1:0] c, input int smp_w);
    fmt_mode_t m;
    logic      rsvd_ok;
    logic      width_ok;
    logic      shift_ok;
    rsvd_ok  = (c[CFG_W-1:RSVD_LSB] == '0);
    width_ok = (c[WIDTH_LSB +: WIDTH_W] == WIDTH_W'(smp_w / 2));
    shift_ok = (c[SHIFT_LSB +: SHIFT_W] == SHIFT_W'(smp_w / 2));
    m.narrow  = rsvd_ok && width_ok && shift_ok;
    m.want_q  = c[WANTQ_BIT];
    m.use_raw = c[RAWSEL_BIT];
    m.shift   = m.narrow ? SHIFT_W'(smp_w / 2) : '0;
    return m;
  endfunction
endpackage

// File: rtl/rxp_cfg_reg.sv
module rxp_cfg_reg
  import rxp_pkg::*;
#(
  parameter int SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output fmt_mode_t        mode,
  output logic             cfg_wr_evt
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= wdata;
  end

  always_comb begin
    mode       = decode_fmt(cfg_q, SMP_W);
    cfg_wr_evt = we;
  end
endmodule

// File: rtl/rxp_src_sel.sv
module rxp_src_sel #(
  parameter int SMP_W = 16,
  parameter int N_SRC = 2
) (
  input  logic                        sel,
  input  logic [N_SRC-1:0]            src_valid,
  input  logic [N_SRC-1:0][SMP_W-1:0] src_i,
  input  logic [N_SRC-1:0][SMP_W-1:0] src_q,
  output logic                        sel_valid,
  output logic [SMP_W-1:0]            sel_i,
  output logic [SMP_W-1:0]            sel_q
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] hit;

  for (genvar s = 0; s < N_SRC; s++) begin : g_hit
    assign hit[s] = (IDX_W'(s) == IDX_W'(sel));
  end

  always_comb begin
    sel_valid = 1'b0;
    sel_i     = '0;
    sel_q     = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (hit[s]) begin
        sel_valid = src_valid[s];
        sel_i     = src_i[s];
        sel_q     = src_q[s];
      end
    end
  end
endmodule

// File: rtl/rxp_packer.sv
module rxp_packer
  import rxp_pkg::*;
#(
  parameter int SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fmt_mode_t        mode,
  input  logic             cfg_wr,
  input  logic             in_valid,
  input  logic [SMP_W-1:0] in_i,
  input  logic [SMP_W-1:0] in_q,
  output logic             out_valid,
  output logic [SMP_W-1:0] out_data
);
  localparam int HALF  = SMP_W / 2;
  localparam int LANES = 2;

  function automatic logic [SMP_W-1:0] scale_word(input logic [SMP_W-1:0] x,
                                                  input logic [SHIFT_W-1:0] sh);
    return SMP_W'($signed(x) >>> sh);
  endfunction

  logic [LANES-1:0][SMP_W-1:0] lane_word;
  logic [LANES-1:0][HALF-1:0]  lane_byte;
  logic                        q_pend;
  logic [SMP_W-1:0]            q_word;
  logic                        half_full;
  logic [HALF-1:0]             half_byte;
  logic                        sample_take;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_word[l] = scale_word((l == 0) ? in_i : in_q, mode.shift);
    assign lane_byte[l] = lane_word[l][HALF-1:0];
  end

  assign sample_take = in_valid && !q_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      q_pend    <= 1'b0;
      q_word    <= '0;
      half_full <= 1'b0;
      half_byte <= '0;
    end else begin
      out_valid <= 1'b0;
      out_data  <= '0;
      if (q_pend) begin
        out_valid <= 1'b1;
        out_data  <= q_word;
        q_pend    <= 1'b0;
      end else if (sample_take) begin
        if (!mode.narrow) begin
          out_valid <= 1'b1;
          out_data  <= lane_word[0];
          if (mode.want_q) begin
            q_pend <= 1'b1;
            q_word <= lane_word[1];
          end
        end else if (mode.want_q) begin
          out_valid <= 1'b1;
          out_data  <= {lane_byte[1], lane_byte[0]};
        end else if (half_full) begin
          out_valid <= 1'b1;
          out_data  <= {lane_byte[0], half_byte};
          half_full <= 1'b0;
        end else begin
          half_byte <= lane_byte[0];
          half_full <= 1'b1;
        end
      end
      if (cfg_wr) half_full <= 1'b0;
    end
  end

  AST_Q_AFTER_I: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_take && !mode.narrow && mode.want_q) |=> (out_valid && q_pend)); // R4
  AST_Q_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    q_pend |=> (out_valid && !q_pend)); // R8
  AST_NARROW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_take && mode.narrow) |=> !q_pend); // R6
  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_take && mode.narrow && !mode.want_q && !half_full && !cfg_wr)
      |=> (half_full && !out_valid)); // R7
  AST_HALF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !half_full); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0)); // R10
endmodule

// File: rtl/rx_fmt_packer.sv
module rx_fmt_packer
  import rxp_pkg::*;
#(
  parameter int SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fmt_we,
  input  logic [31:0]      fmt_wdata,
  input  logic             filt_valid,
  input  logic [SMP_W-1:0] filt_i,
  input  logic [SMP_W-1:0] filt_q,
  input  logic             raw_valid,
  input  logic [SMP_W-1:0] raw_i,
  input  logic [SMP_W-1:0] raw_q,
  output logic             out_valid,
  output logic [SMP_W-1:0] out_data
);
  fmt_mode_t        mode;
  logic             cfg_wr_evt;
  logic             sel_valid;
  logic [SMP_W-1:0] sel_i;
  logic [SMP_W-1:0] sel_q;

  rxp_cfg_reg #(.SMP_W(SMP_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (fmt_we),
    .wdata     (fmt_wdata),
    .mode      (mode),
    .cfg_wr_evt(cfg_wr_evt)
  );

  rxp_src_sel #(.SMP_W(SMP_W), .N_SRC(2)) u_sel (
    .sel      (mode.use_raw),
    .src_valid({raw_valid, filt_valid}),
    .src_i    ({raw_i, filt_i}),
    .src_q    ({raw_q, filt_q}),
    .sel_valid(sel_valid),
    .sel_i    (sel_i),
    .sel_q    (sel_q)
  );

  rxp_packer #(.SMP_W(SMP_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .cfg_wr   (cfg_wr_evt),
    .in_valid (sel_valid),
    .in_i     (sel_i),
    .in_q     (sel_q),
    .out_valid(out_valid),
    .out_data (out_data)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid); // R1
endmodule

// File: tb/rx_fmt_packer_tb_top.sv
module rx_fmt_packer_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt_we = 1'b0;
  logic [31:0] fmt_wdata = '0;
  logic        filt_valid = 1'b0;
  logic [15:0] filt_i = '0, filt_q = '0;
  logic        raw_valid = 1'b0;
  logic [15:0] raw_i = '0, raw_q = '0;
  logic        out_valid;
  logic [15:0] out_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int seed = 7;

  // reference model state
  int m_cfg = 0;
  bit m_qpend = 0;
  int m_qword = 0;
  bit m_half = 0;
  int m_hbyte = 0;
  bit m_ov = 0;
  int m_od = 0;

  always #(CLK_P/2) clk = ~clk;

  rx_fmt_packer dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_we(fmt_we), .fmt_wdata(fmt_wdata),
    .filt_valid(filt_valid), .filt_i(filt_i), .filt_q(filt_q),
    .raw_valid(raw_valid), .raw_i(raw_i), .raw_q(raw_q),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic int hi_byte(input int x);
    return (x / 256) % 256;
  endfunction

  function automatic int rnd16();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 16'hFFFF;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic cyc(input bit we, input int wd, input bit fv, input int fi, input int fq,
                     input bit rv, input int ri, input int rq, input string tag);
    bit use_raw, v, nar, wq, n_ov;
    int i, q, n_od;
    @(negedge clk);
    fmt_we = we; fmt_wdata = wd;
    filt_valid = fv; filt_i = fi[15:0]; filt_q = fq[15:0];
    raw_valid = rv;  raw_i = ri[15:0];  raw_q = rq[15:0];
    use_raw = ((m_cfg >> 10) & 1) == 1;
    v = use_raw ? rv : fv;
    i = (use_raw ? ri : fi) & 16'hFFFF;
    q = (use_raw ? rq : fq) & 16'hFFFF;
    nar = ((m_cfg >>> 11) == 0) && (((m_cfg >> 4) & 31) == 8) && ((m_cfg & 15) == 8);
    wq = ((m_cfg >> 9) & 1) == 1;
    n_ov = 0; n_od = 0;
    if (m_qpend) begin
      n_ov = 1; n_od = m_qword; m_qpend = 0;
    end else if (v) begin
      if (!nar) begin
        n_ov = 1; n_od = i;
        if (wq) begin m_qpend = 1; m_qword = q; end
      end else if (wq) begin
        n_ov = 1; n_od = hi_byte(q) * 256 + hi_byte(i);
      end else if (m_half) begin
        n_ov = 1; n_od = hi_byte(i) * 256 + m_hbyte; m_half = 0;
      end else begin
        m_hbyte = hi_byte(i); m_half = 1;
      end
    end
    if (we) begin m_half = 0; m_cfg = wd; end
    m_ov = n_ov; m_od = n_od;
    @(posedge clk);
    #(CLK_P/4);
    checks++;
    if (out_valid !== m_ov || out_data !== m_od[15:0]) begin
      errors++;
      $display("FAIL %s: actual valid=%0b data=%04h expected valid=%0b data=%04h",
               tag, out_valid, out_data, m_ov, m_od[15:0]);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(input int val, input string tag);
    cyc(1, val, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic smp(input int i, input int q, input string tag);
    cyc(0, 0, 1, i, q, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    checks++; // R1 outputs held low during reset
    if (out_valid !== 1'b0 || out_data !== 16'h0) begin
      errors++;
      $display("FAIL R1 reset: actual valid=%0b data=%04h expected valid=0 data=0000",
               out_valid, out_data);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(2, "R1");
    smp(16'h8001, 16'h1234, "R1");      // default: I only, 16-bit
    idle(2, "R10");

    // R2: Q bit with width 0 falls back to 16-bit I+Q
    wr(32'h200, "R2");
    smp(16'hF00D, 16'h0BAD, "R4"); idle(2, "R4");
    for (int k = 0; k < 6; k++) begin
      smp(rnd16(), rnd16(), "R4"); idle(1, "R4");
    end
    // R8: back-to-back samples collide with the pending Q word
    for (int k = 0; k < 8; k++) smp(rnd16(), rnd16(), "R8");
    idle(2, "R8");

    // R5: I only, 16-bit, every cycle
    wr(32'h000, "R5");
    for (int k = 0; k < 6; k++) smp(rnd16(), rnd16(), "R5");
    idle(1, "R5");

    // R6: 8-bit with Q
    wr(32'h288, "R6");
    smp(16'h8123, 16'h7F80, "R6");
    smp(16'hFFFF, 16'h0100, "R6");
    for (int k = 0; k < 6; k++) smp(rnd16(), rnd16(), "R6");
    idle(1, "R6");

    // R7: 8-bit, I only, pairs
    wr(32'h088, "R7");
    smp(16'h1200, 0, "R7"); idle(1, "R7"); smp(16'hAB00, 0, "R7");
    for (int k = 0; k < 6; k++) smp(rnd16(), rnd16(), "R7");
    idle(1, "R7");

    // R2: near misses fall back to 16-bit, shift 0
    wr(32'h0800_0288, "R2"); smp(16'h8765, 16'h4321, "R2"); idle(2, "R2");
    wr(32'h280, "R2");       smp(16'h89AB, 16'hCDEF, "R2"); idle(2, "R2");
    wr(32'h298, "R2");       smp(16'h0F0F, 16'hF0F0, "R2"); idle(2, "R2");

    // R3: stream select
    wr(32'h688, "R3");
    cyc(0, 0, 1, 16'h1111, 16'h2222, 0, 0, 0, "R3");   // filtered ignored
    cyc(0, 0, 1, 16'h1111, 16'h2222, 1, 16'hA5C3, 16'h5A3C, "R3");
    cyc(0, 0, 0, 0, 0, 1, 16'h8000, 16'h7FFF, "R3");
    wr(32'h288, "R3");
    cyc(0, 0, 0, 0, 0, 1, 16'h3333, 16'h4444, "R3");   // raw ignored
    cyc(0, 0, 1, 16'h5500, 16'h6600, 1, 16'h7700, 16'h8800, "R3");
    idle(1, "R3");

    // R9: write against a held byte and in the same cycle as samples
    wr(32'h088, "R9");
    smp(16'h0100, 0, "R9");
    cyc(1, 32'h088, 1, 16'h0200, 0, 0, 0, 0, "R9");    // completes pair under old format
    smp(16'h0300, 0, "R9");
    wr(32'h088, "R9");                                  // discard held byte
    smp(16'h0400, 0, "R9"); smp(16'h0500, 0, "R9");
    cyc(1, 32'h088, 1, 16'h0600, 0, 0, 0, 0, "R9");    // stored then discarded
    smp(16'h0700, 0, "R9"); smp(16'h0800, 0, "R9");
    wr(32'h200, "R9");
    cyc(1, 32'h288, 1, 16'hC001, 16'hD002, 0, 0, 0, "R9"); // old 16-bit IQ format
    idle(1, "R9");
    smp(16'hC001, 16'hD002, "R9");
    cyc(1, 32'h200, 1, 16'h1357, 16'h2468, 0, 0, 0, "R9"); // old 8-bit format
    smp(16'h1357, 16'h2468, "R9");
    idle(3, "R10");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule